// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block is a bank of 32-bit control words for chip-level settings: reset control, clock selection, PLL parameters, pin multiplexing, scratch words and strap copies. Software reaches it through a simple word-addressed bus port that uses single-cycle requests. A write to the key word at offset 0x00 either opens or closes a protected window of registers. While the window is closed, writes into it are dropped and flagged on a one-cycle error output.

Reset values come from one of two computed default sets. The set is chosen from a revision code that is sampled while reset is held. On the same reset, the revision code, two strap words and a default key are copied into their own registers. A nonzero default key therefore brings the bank up unlocked. A random-data input is passed straight to software through a read-only data word. The control bits have no effect inside this block: consumers elsewhere decode them.

Top module: `sysctl_keyreg`

## Requirements
- R1: The register index is the byte address shifted right by two. A request with a nonzero address bits [1:0] is rejected: a write stores nothing and raises the error pulse, and a read returns zero.
- R2: A write to offset 0x00 stores 1 when the data equals MAGIC_KEY (default 32'h1688A8A8) and stores 0 otherwise. The write is accepted whatever the lock state. Offset 0x00 reads back the stored key word.
- R3: While the key word is zero, a write to any offset from 0x04 through 0x100 is dropped and raises the error pulse. When the key word is nonzero, those registers accept plain writes, including the eight scratch words at 0x50..0x6C.
- R4: Registers from offset 0x104 up to the end of the bank accept writes in every lock state, and such writes raise no error.
- R5: A read of offset 0x78 returns the value on rand_in in the request cycle. This holds for every value of the control word at 0x74.
- R6: With an early-family revision code (32'h02000303 or 32'h02010303), reset loads 0x24=32'h00000291, 0x88=32'h01000000, 0x8C=32'h000000FF and 0x9C=32'h003FFFF3. With a late-family code (32'h04000303 or 32'h04010303), these become 32'h93000400, 32'h03000000, 32'h00000000 and 32'h023FFFF3.
- R7: Defaults shared by both families include 0x04=32'hFFCFFEDC, 0x40=32'h000000C0 (memory init done) and 0x1A4=32'h00002402. Offsets that have no listed default reset to zero, for example 0x14.
- R8: On reset, 0x7C takes rev_in, 0x70 takes strap_a_in, 0xD0 takes strap_b_in and 0x00 takes key_default_in.
- R9: Offsets 0x70, 0x78, 0x7C and 0xD0 are read-only. A write to one of them changes nothing and raises the error pulse.
- R10: The bank spans 106 words, up to offset 0x1A4. A write at byte address 0x1A8 or above changes nothing and raises the error pulse. A read there returns zero.
- R11: Read data appears on bus_rdata one cycle after the read request and holds until the next read. The error pulse is high for exactly the cycle after the rejected write.
- R12: An unrecognised revision code selects the late-family defaults and sets bad_rev. bad_rev then holds its value until the next reset, which evaluates it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads defaults |
| bus_en | input | 1 | Request valid for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address inside the 4 KiB region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| err_pulse | output | 1 | One-cycle flag for a rejected write |
| rev_in | input | 32 | Revision code, sampled at reset |
| strap_a_in | input | 32 | First strap word, sampled at reset |
| strap_b_in | input | 32 | Second strap word, sampled at reset |
| key_default_in | input | 32 | Key word value loaded at reset |
| rand_in | input | 32 | Random word presented at offset 0x78 |
| bad_rev | output | 1 | Sticky flag for an unrecognised revision |

## Verification
The hardest case to reach is the boundary between the locked window and the always-open area, taken in both lock states. The bench writes to 0x100 and to 0x104 while the bank is locked. It then unlocks the bank with the magic value, relocks it with a wrong value, and reads every target back to prove that a dropped write left no trace. It also starts from a reset with a nonzero default key and from a reset with an unknown revision code. These runs show that the lock state and the choice of default set both come from inputs sampled at reset, not from any bus traffic.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int WORD_W = 32;

    // word indices whose position drives behaviour
    localparam int IDX_KEY      = 0;
    localparam int IDX_STRAP_A  = 28;  // 0x70
    localparam int IDX_RAND     = 30;  // 0x78
    localparam int IDX_REV      = 31;  // 0x7C
    localparam int IDX_STRAP_B  = 52;  // 0xD0
    localparam int IDX_OPEN_LO  = 65;  // 0x104: first always-writable word

    localparam logic [WORD_W-1:0] REV_EARLY_0 = 32'h0200_0303;
    localparam logic [WORD_W-1:0] REV_EARLY_1 = 32'h0201_0303;
    localparam logic [WORD_W-1:0] REV_LATE_0  = 32'h0400_0303;
    localparam logic [WORD_W-1:0] REV_LATE_1  = 32'h0401_0303;

    typedef enum logic [1:0] {
        FAM_EARLY   = 2'd0,
        FAM_LATE    = 2'd1,
        FAM_UNKNOWN = 2'd2
    } family_e;

    typedef struct packed {
        logic aligned;
        logic in_range;
        logic is_key;
        logic is_rand;
        logic read_only;
        logic blocked;
        logic writable;
    } acc_flags_t;

    function automatic family_e classify_rev(input logic [WORD_W-1:0] rev);
        if (rev == REV_EARLY_0 || rev == REV_EARLY_1) return FAM_EARLY;
        if (rev == REV_LATE_0 || rev == REV_LATE_1)   return FAM_LATE;
        return FAM_UNKNOWN;
    endfunction

    // default contents; unknown family falls back to the late set
    function automatic logic [WORD_W-1:0] table_word(input int idx, input family_e fam);
        logic late;
        late = (fam != FAM_EARLY);
        case (idx)
            1:   return 32'hFFCF_FEDC;
            2:   return 32'hF3F4_0000;
            3:   return 32'h19FC_3E8B;
            7:   return 32'h0002_6108;
            8:   return 32'h0003_0291;
            9:   return late ? 32'h9300_0400 : 32'h0000_0291;
            11:  return 32'h0000_0010;
            12:  return 32'h2000_1A03;
            13:  return 32'h2000_1A03;
            14:  return 32'h0400_0030;
            15:  return 32'h0000_0001;
            16:  return 32'h0000_00C0;
            19:  return 32'h0000_0023;
            29:  return 32'h0000_000E;
            33:  return 32'h0000_F000;
            34:  return late ? 32'h0300_0000 : 32'h0100_0000;
            35:  return late ? 32'h0000_0000 : 32'h0000_00FF;
            36:  return 32'h0000_A000;
            39:  return late ? 32'h023F_FFF3 : 32'h003F_FFF3;
            41:  return 32'hFFFF_0000;
            42:  return 32'h000F_FFFF;
            56:  return 32'h0000_00FF;
            57:  return 32'h0000_00FF;
            65:  return 32'h8000_0000;
            68:  return 32'h1E60_0000;
            69:  return 32'hC000_0000;
            88:  return 32'h0000_1903;
            96:  return 32'h0000_007B;
            105: return 32'h0000_2402;
            default: return '0;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] reset_word(
        input int idx, input family_e fam,
        input logic [WORD_W-1:0] rev, input logic [WORD_W-1:0] sa,
        input logic [WORD_W-1:0] sb, input logic [WORD_W-1:0] key);
        case (idx)
            IDX_KEY:     return key;
            IDX_STRAP_A: return sa;
            IDX_REV:     return rev;
            IDX_STRAP_B: return sb;
            default:     return table_word(idx, fam);
        endcase
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = 106
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                lock_active,
    output logic [ADDR_W-3:0]   idx,
    output acc_flags_t          flags
);
    localparam int IDX_W = ADDR_W - 2;

    always_comb begin
        idx             = addr[ADDR_W-1:2];
        flags.aligned   = (addr[1:0] == 2'b00);
        flags.in_range  = (int'(idx) < NUM_REGS);
        flags.is_key    = (idx == IDX_W'(IDX_KEY));
        flags.is_rand   = (idx == IDX_W'(IDX_RAND));
        flags.read_only = (idx == IDX_W'(IDX_STRAP_A)) || (idx == IDX_W'(IDX_RAND)) ||
                          (idx == IDX_W'(IDX_REV))     || (idx == IDX_W'(IDX_STRAP_B));
        flags.blocked   = lock_active && !flags.is_key && (int'(idx) < IDX_OPEN_LO);
        flags.writable  = flags.aligned && flags.in_range &&
                          !flags.read_only && !flags.blocked;
    end
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
    import sysctl_pkg::*;
#(
    parameter int IDX_W    = 10,
    parameter int NUM_REGS = 106
) (
    input  logic              clk,
    input  logic              rst,
    input  family_e           fam,
    input  logic [WORD_W-1:0] rev_in,
    input  logic [WORD_W-1:0] strap_a_in,
    input  logic [WORD_W-1:0] strap_b_in,
    input  logic [WORD_W-1:0] key_default_in,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] key_word
);
    logic [WORD_W-1:0] mem [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++)
                mem[i] <= reset_word(i, fam, rev_in, strap_a_in, strap_b_in, key_default_in);
        end else if (wr_en && int'(wr_idx) < NUM_REGS) begin
            mem[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        rd_word  = (int'(rd_idx) < NUM_REGS) ? mem[rd_idx] : '0;
        key_word = mem[IDX_KEY];
    end
endmodule

// File: rtl/sysctl_keyreg.sv
module sysctl_keyreg
    import sysctl_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          NUM_REGS  = 106,
    parameter logic [31:0] MAGIC_KEY = 32'h1688_A8A8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        err_pulse,
    input  logic [31:0] rev_in,
    input  logic [31:0] strap_a_in,
    input  logic [31:0] strap_b_in,
    input  logic [31:0] key_default_in,
    input  logic [31:0] rand_in,
    output logic        bad_rev
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  idx;
    acc_flags_t        flags;
    logic [WORD_W-1:0] key_word;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] wr_value;
    logic              lock_active;
    logic              wr_req;
    logic              wr_ok;
    family_e           fam;

    assign lock_active = (key_word == '0);
    assign wr_req      = bus_en && bus_we;
    assign wr_ok       = wr_req && flags.writable;
    assign fam         = classify_rev(rev_in);
    assign wr_value    = flags.is_key ? WORD_W'(bus_wdata == MAGIC_KEY) : bus_wdata;

    sysctl_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
        .addr        (bus_addr),
        .lock_active (lock_active),
        .idx         (idx),
        .flags       (flags)
    );

    sysctl_bank #(.IDX_W(IDX_W), .NUM_REGS(NUM_REGS)) u_bank (
        .clk            (clk),
        .rst            (rst),
        .fam            (fam),
        .rev_in         (rev_in),
        .strap_a_in     (strap_a_in),
        .strap_b_in     (strap_b_in),
        .key_default_in (key_default_in),
        .wr_en          (wr_ok),
        .wr_idx         (idx),
        .wr_data        (wr_value),
        .rd_idx         (idx),
        .rd_word        (rd_word),
        .key_word       (key_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            err_pulse <= 1'b0;
            bad_rev   <= (fam == FAM_UNKNOWN);
        end else begin
            err_pulse <= wr_req && !flags.writable;
            if (bus_en && !bus_we) begin
                if (!(flags.aligned && flags.in_range))
                    bus_rdata <= '0;
                else if (flags.is_rand)
                    bus_rdata <= rand_in;
                else
                    bus_rdata <= rd_word;
            end
        end
    end
endmodule

// File: rtl/sysctl_keyreg_chk.sv
module sysctl_keyreg_chk #(
    parameter int          NUM_REGS  = 106,
    parameter logic [31:0] MAGIC_KEY = 32'h1688_A8A8
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_en,
    input logic        bus_we,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        err_pulse,
    input logic [31:0] rand_in,
    input logic        bad_rev,
    input logic [31:0] key_word
);
    logic [9:0] widx;
    logic       aligned;
    assign widx    = bus_addr[11:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    // R3
    a_r3_locked_write_flags: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && aligned && key_word == 32'd0 && widx > 10'd0 && widx < 10'd65)
        |=> err_pulse);

    // R4
    a_r4_open_write_clean: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && aligned && widx >= 10'd65 && int'(widx) < NUM_REGS)
        |=> !err_pulse);

    // R2
    a_r2_key_result: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && bus_addr == 12'h000)
        |=> key_word == (($past(bus_wdata) == MAGIC_KEY) ? 32'd1 : 32'd0));

    // R5
    a_r5_rand_read: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_we && bus_addr == 12'h078) |=> bus_rdata == $past(rand_in));

    // R10
    a_r10_oob_read_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_we && int'(widx) >= NUM_REGS) |=> bus_rdata == 32'd0);

    // R11
    a_r11_err_after_write: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> $past(bus_en && bus_we));

    // R12
    a_r12_badrev_sticky: assert property (@(posedge clk) disable iff (rst)
        bad_rev == $past(bad_rev));
endmodule

bind sysctl_keyreg sysctl_keyreg_chk #(.NUM_REGS(NUM_REGS), .MAGIC_KEY(MAGIC_KEY)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .err_pulse (err_pulse),
    .rand_in   (rand_in),
    .bad_rev   (bad_rev),
    .key_word  (key_word)
);

// File: tb/sysctl_keyreg_tb.sv
module sysctl_keyreg_tb_top;

    localparam logic [31:0] MAGIC = 32'h1688_A8A8;
    localparam logic [31:0] EARLY = 32'h0200_0303;
    localparam logic [31:0] EARLY2 = 32'h0201_0303;
    localparam logic [31:0] LATE  = 32'h0401_0303;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        err_pulse;
    logic [31:0] rev_in = EARLY;
    logic [31:0] strap_a_in = 32'hA5A5_0001;
    logic [31:0] strap_b_in = 32'h5A5A_0002;
    logic [31:0] key_default_in = 32'd0;
    logic [31:0] rand_in = 32'd0;
    logic        bad_rev;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    sysctl_keyreg dut_i (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .err_pulse(err_pulse), .rev_in(rev_in), .strap_a_in(strap_a_in),
        .strap_b_in(strap_b_in), .key_default_in(key_default_in),
        .rand_in(rand_in), .bad_rev(bad_rev)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [31:0] rev, input logic [31:0] key);
        @(negedge clk);
        rst = 1'b1; rev_in = rev; key_default_in = key; bus_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, output logic e);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        e = err_pulse;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic expect_rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, $sformatf("read %03h", a), d, exp);
    endtask

    task automatic expect_wr(input string req, input logic [11:0] a,
                             input logic [31:0] d, input logic exp_err);
        logic e;
        wr(a, d, e);
        check(req, $sformatf("err on write %03h", a), {31'b0, e}, {31'b0, exp_err});
    endtask

    task automatic t_reset_early;
        do_reset(EARLY, 32'd0);
        check("R12", "bad_rev early", {31'b0, bad_rev}, 32'd0);
        check("R11", "err idle after reset", {31'b0, err_pulse}, 32'd0);
        expect_rd("R6", 12'h024, 32'h0000_0291);
        expect_rd("R6", 12'h088, 32'h0100_0000);
        expect_rd("R6", 12'h08C, 32'h0000_00FF);
        expect_rd("R6", 12'h09C, 32'h003F_FFF3);
        expect_rd("R7", 12'h004, 32'hFFCF_FEDC);
        expect_rd("R7", 12'h040, 32'h0000_00C0);
        expect_rd("R7", 12'h1A4, 32'h0000_2402);
        expect_rd("R7", 12'h014, 32'h0000_0000);
        expect_rd("R8", 12'h07C, EARLY);
        expect_rd("R8", 12'h070, 32'hA5A5_0001);
        expect_rd("R8", 12'h0D0, 32'h5A5A_0002);
        expect_rd("R8", 12'h000, 32'd0);
    endtask

    task automatic t_lock_window;
        // locked: window drops writes, open area accepts
        expect_wr("R3", 12'h050, 32'h1111_2222, 1'b1);
        expect_rd("R3", 12'h050, 32'd0);
        expect_wr("R3", 12'h100, 32'hDEAD_0001, 1'b1);
        expect_rd("R3", 12'h100, 32'd0);
        expect_wr("R4", 12'h104, 32'hCAFE_0104, 1'b0);
        expect_rd("R4", 12'h104, 32'hCAFE_0104);
        expect_wr("R4", 12'h1A0, 32'h0000_BEEF, 1'b0);
        expect_rd("R4", 12'h1A0, 32'h0000_BEEF);
    endtask

    task automatic t_key;
        expect_wr("R2", 12'h000, 32'h1688_A8A9, 1'b0);
        expect_rd("R2", 12'h000, 32'd0);
        expect_wr("R2", 12'h000, MAGIC, 1'b0);
        expect_rd("R2", 12'h000, 32'd1);
        expect_wr("R3", 12'h050, 32'h1111_2222, 1'b0);
        expect_rd("R3", 12'h050, 32'h1111_2222);
        expect_wr("R3", 12'h06C, 32'h3333_4444, 1'b0);
        expect_rd("R3", 12'h06C, 32'h3333_4444);
        expect_wr("R3", 12'h100, 32'h0000_0100, 1'b0);
        expect_rd("R3", 12'h100, 32'h0000_0100);
        // relock with a wrong value
        expect_wr("R2", 12'h000, 32'hFFFF_FFFF, 1'b0);
        expect_rd("R2", 12'h000, 32'd0);
        expect_wr("R3", 12'h004, 32'h0, 1'b1);
        expect_rd("R3", 12'h004, 32'hFFCF_FEDC);
    endtask

    task automatic t_read_only;
        expect_wr("R2", 12'h000, MAGIC, 1'b0);
        expect_wr("R9", 12'h07C, 32'h1234_5678, 1'b1);
        expect_rd("R9", 12'h07C, EARLY);
        expect_wr("R9", 12'h070, 32'h1234_5678, 1'b1);
        expect_rd("R9", 12'h070, 32'hA5A5_0001);
        expect_wr("R9", 12'h0D0, 32'h1234_5678, 1'b1);
        expect_rd("R9", 12'h0D0, 32'h5A5A_0002);
        expect_wr("R9", 12'h078, 32'h1234_5678, 1'b1);
    endtask

    task automatic t_rand;
        logic [31:0] d;
        expect_wr("R5", 12'h074, 32'h0, 1'b0);   // enable bit cleared
        rand_in = 32'h0BAD_F00D;
        rd(12'h078, d);
        check("R5", "rand first", d, 32'h0BAD_F00D);
        rand_in = 32'h7777_1234;
        rd(12'h078, d);
        check("R5", "rand second", d, 32'h7777_1234);
        // R11: read data holds while idle
        repeat (3) @(negedge clk);
        check("R11", "rdata holds", bus_rdata, 32'h7777_1234);
    endtask

    task automatic t_range_align;
        expect_wr("R10", 12'h1A8, 32'h5555_5555, 1'b1);
        expect_rd("R10", 12'h1A8, 32'd0);
        expect_rd("R10", 12'hFFC, 32'd0);
        expect_wr("R1", 12'h041, 32'h5555_5555, 1'b1);
        expect_rd("R1", 12'h040, 32'h0000_00C0);
        expect_rd("R1", 12'h042, 32'd0);
        expect_rd("R1", 12'h008, 32'hF3F4_0000);
        // err lasts one cycle only
        expect_wr("R11", 12'h1AC, 32'h0, 1'b1);
        @(negedge clk);
        check("R11", "err drops", {31'b0, err_pulse}, 32'd0);
    endtask

    task automatic t_late_unlocked;
        do_reset(LATE, 32'h0000_0007);
        check("R12", "bad_rev late", {31'b0, bad_rev}, 32'd0);
        expect_rd("R6", 12'h024, 32'h9300_0400);
        expect_rd("R6", 12'h088, 32'h0300_0000);
        expect_rd("R6", 12'h08C, 32'h0000_0000);
        expect_rd("R6", 12'h09C, 32'h023F_FFF3);
        expect_rd("R8", 12'h000, 32'h0000_0007);
        expect_wr("R8", 12'h054, 32'hABCD_0054, 1'b0);
        expect_rd("R8", 12'h054, 32'hABCD_0054);
        expect_rd("R8", 12'h07C, LATE);
    endtask

    task automatic t_bad_rev;
        do_reset(32'h0999_0000, 32'd0);
        check("R12", "bad_rev set", {31'b0, bad_rev}, 32'd1);
        expect_rd("R12", 12'h024, 32'h9300_0400);
        expect_rd("R12", 12'h09C, 32'h023F_FFF3);
        expect_wr("R12", 12'h000, MAGIC, 1'b0);
        expect_wr("R12", 12'h0C0, 32'h1, 1'b0);
        check("R12", "bad_rev sticky", {31'b0, bad_rev}, 32'd1);
        do_reset(EARLY2, 32'd0);
        check("R12", "bad_rev cleared", {31'b0, bad_rev}, 32'd0);
        expect_rd("R6", 12'h08C, 32'h0000_00FF);
    endtask

    initial begin
        t_reset_early();
        t_lock_window();
        t_key();
        t_read_only();
        t_rand();
        t_range_align();
        t_late_unlocked();
        t_bad_rev();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule